// File: doc/BRIEF.md
# Fractional-ratio clock tick generator

This block produces a one-cycle enable pulse on `tick_o` at an average rate of `RATE_B` pulses for every `RATE_A` cycles of `clk_i`. The ratio `RATE_A/RATE_B` does not have to be an integer. The block keeps a signed phase error in an accumulator. On each edge it looks only at the accumulator's sign bit to choose one of two constant increments. A zero or positive error adds `RATE_B - RATE_A` and asks for a pulse. A negative error adds `RATE_B`.

Pulse spacing varies by up to one input period from pulse to pulse. The count of pulses never drifts from the exact ratio. The output comes from a register, so it is meant to drive clock-enable inputs of logic in the `clk_i` domain. It is not meant to be used as a derived clock. Both rates are elaboration-time parameters.

Top module: `frac_tick_gen`

## Requirements
- R1: While `rst_ni` is low the accumulator is zero and `tick_o` is low. The first rising edge after release emits a pulse, so `tick_o` is high in the following cycle.
- R2: Number the edges after reset release n = 0, 1, 2, and so on. `tick_o` is high in the cycle after edge n exactly when (n·RATE_B mod RATE_A) < RATE_B. It is low otherwise.
- R3: The accumulator always stays within [RATE_B − RATE_A, RATE_B − 1]. It is clog2(RATE_A)+1 bits wide and never wraps.
- R4: Each consecutive run of RATE_A edges, counted from reset release, contains exactly RATE_B pulses.
- R5: The distance between two consecutive pulses is always floor(RATE_A/RATE_B) or ceil(RATE_A/RATE_B) cycles.
- R6: When 2·RATE_B ≤ RATE_A, no pulse lasts more than one cycle.
- R7: Elaboration rejects the parameter set when RATE_B = 0 or RATE_B ≥ RATE_A.
- R8: With the default parameters (RATE_A = 14152300, RATE_B = 24) the block follows R2. It pulses on edge 0 and then stays silent for the following 589679 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; the accumulator updates on each rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_o | output | 1 | Registered one-cycle enable pulse |

## Verification
Several parameter sets run side by side against one shared reset schedule. The sets cover an integer ratio, a ratio just above one, a near-half ratio and the large default ratio. Reset lengths and pause points come from a seeded random source.

Every cycle's output is compared with the modular-arithmetic rule. A wrong increment or a wrong sign test moves a pulse by at least one edge. A wrong width makes the error wrap and emit a burst of pulses.

Each full window of RATE_A edges is checked for exactly RATE_B pulses. This catches slow drift that a short run would miss. Gap checks catch pulses that are doubled or skipped. Repeated mid-run resets show whether the first pulse really lands on edge 0, and whether any stale error survives a reset.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  // signed accumulator width: magnitude of RATE_A plus sign
  function automatic int unsigned acc_width(input int unsigned rate_a);
    return $clog2(rate_a) + 1;
  endfunction
endpackage

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
  parameter int unsigned RATE_A = 7,
  parameter int unsigned RATE_B = 3,
  parameter int unsigned W      = frac_tick_pkg::acc_width(RATE_A)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] acc_o,
  output logic         due_o
);
  localparam logic [W-1:0] STEP_UP = W'(RATE_B);
  localparam logic [W-1:0] STEP_DN = W'(RATE_B) - W'(RATE_A);
  localparam logic [W-1:0] LIM_HI  = W'(RATE_B - 1);

  logic [W-1:0] acc_q;
  logic [W-1:0] step;

  // sign bit alone picks the increment
  assign step = acc_q[W-1] ? STEP_UP : STEP_DN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + step;
  end

  assign acc_o = acc_q;
  assign due_o = ~acc_q[W-1];

  AST_ACC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(acc_q) >= $signed(STEP_DN)) && ($signed(acc_q) <= $signed(LIM_HI))); // R3
endmodule

// File: rtl/frac_tick_reg.sv
module frac_tick_reg #(
  parameter int unsigned RATE_A = 7,
  parameter int unsigned RATE_B = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic due_i,
  output logic tick_o
);
  logic tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= due_i;
  end

  assign tick_o = tick_q;

  generate
    if (2 * RATE_B <= RATE_A) begin : g_sparse
      AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |=> !tick_q); // R6
    end
  endgenerate
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
  parameter int unsigned RATE_A = 14152300,
  parameter int unsigned RATE_B = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = frac_tick_pkg::acc_width(RATE_A);

  generate
    if (RATE_B == 0 || RATE_B >= RATE_A) begin : g_bad_cfg
      $error("frac_tick_gen: need 0 < RATE_B < RATE_A"); // R7
    end
  endgenerate

  logic [W-1:0] acc;
  logic         due;

  frac_phase_acc #(.RATE_A(RATE_A), .RATE_B(RATE_B), .W(W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_o (acc),
    .due_o (due)
  );

  frac_tick_reg #(.RATE_A(RATE_A), .RATE_B(RATE_B)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .due_i (due),
    .tick_o(tick_o)
  );

  AST_FIRST_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |=> tick_o); // R1
  AST_TICK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && tick_o) |-> ($signed(acc) < $signed($past(acc)))); // R2
  AST_IDLE_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !tick_o) |-> ($signed(acc) > $signed($past(acc)))); // R2
endmodule

// File: tb/frac_tick_gen_test.sv
module frac_tick_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSET = 6;
  localparam int unsigned AS [NSET] = '{7, 10, 13, 100, 5, 14152300};
  localparam int unsigned BS [NSET] = '{3, 1, 5, 37, 4, 24};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_tick(input longint n, input longint a, input longint b);
    return ((n * b) % a) < b;
  endfunction

  function automatic longint gap_lo(input longint a, input longint b);
    return a / b;
  endfunction

  function automatic longint gap_hi(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  logic [NSET-1:0] tick;

  generate
    for (genvar g = 0; g < NSET; g++) begin : g_set
      localparam int unsigned PA = AS[g];
      localparam int unsigned PB = BS[g];
      longint e_cnt;
      longint last_tick;
      longint win_ticks;

      if (g == 0) begin : g_uut
        frac_tick_gen #(.RATE_A(PA), .RATE_B(PB)) uut (
          .clk_i(clk), .rst_ni(rst_n), .tick_o(tick[g]));
      end else begin : g_dut
        frac_tick_gen #(.RATE_A(PA), .RATE_B(PB)) dut (
          .clk_i(clk), .rst_ni(rst_n), .tick_o(tick[g]));
      end

      always @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_cnt <= 0;
        else        e_cnt <= e_cnt + 1;
      end

      always @(negedge clk) begin
        if (!done) begin
          if (!rst_n) begin
            chk(tick[g] == 1'b0, "R1 reset low", longint'(tick[g]), 0);
            last_tick = -1;
            win_ticks = 0;
          end else if (e_cnt > 0) begin
            longint n;
            n = e_cnt - 1;
            if (n == 0)
              chk(tick[g] == 1'b1, "R1 first tick", longint'(tick[g]), 1);
            if (PA > 1000)
              chk(tick[g] == exp_tick(n, PA, PB), "R8 ref ratio", longint'(tick[g]),
                  longint'(exp_tick(n, PA, PB)));
            else
              chk(tick[g] == exp_tick(n, PA, PB), "R2 tick rule", longint'(tick[g]),
                  longint'(exp_tick(n, PA, PB)));
            if (tick[g]) begin
              win_ticks++;
              if (last_tick >= 0) begin
                chk((n - last_tick) >= gap_lo(PA, PB) && (n - last_tick) <= gap_hi(PA, PB),
                    "R5 gap", n - last_tick, gap_lo(PA, PB));
                if (2 * PB <= PA)
                  chk((n - last_tick) >= 2, "R6 single pulse", n - last_tick, 2);
              end
              last_tick = n;
            end
            if (((n + 1) % PA) == 0) begin
              chk(win_ticks == PB, "R4 window count", win_ticks, longint'(PB));
              win_ticks = 0;
            end
          end
        end
      end
    end
  endgenerate

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    // directed: long run, full windows of largest small ratio
    repeat (450) @(posedge clk);
    for (int it = 0; it < 24; it++) begin
      #(CLK_PERIOD/4) rst_n = 1'b0;
      repeat ($urandom_range(1, 4)) @(posedge clk);
      #(CLK_PERIOD/4) rst_n = 1'b1;
      // directed corner: very short runs every few iterations
      if (it % 6 == 0) repeat ($urandom_range(1, 3)) @(posedge clk);
      else             repeat ($urandom_range(40, 3000)) @(posedge clk);
    end
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule